// File: doc/BRIEF.md
# Section-Mapped Address Translator with Tagged TLB

This block turns 32-bit virtual addresses into physical addresses for one requester. Memory is mapped in 1 MB sections. A single flat table in memory holds 4096 word-sized descriptors, one for each virtual section number. Recently used mappings are kept in a small fully associative TLB. Each TLB entry is tagged with the address-space identifier (ASID) that was current when the entry was loaded, so several processes can use the same virtual addresses and still reach different physical memory.

A TLB hit answers one cycle after the request is accepted. On a miss the block fetches the descriptor itself through a read port to memory. A valid section descriptor is loaded into the TLB and the response is returned. Any other descriptor gives a translation fault and is not cached.

Software switches address spaces by changing only two inputs: the table base and the current ASID. Cached mappings of other address spaces stay in the TLB, and entries marked global are shared by every space. Separate commands flush the TLB entries of one ASID or all entries. When translation is disabled, addresses pass through unchanged and no fetch is made.

Top module: `sect_mmu`

## Requirements
- R1: While mmu_en_i is low, an accepted request answers one cycle later with rsp_paddr_o equal to the virtual address, rsp_fault_o low and rsp_cacheable_o low, and no memory fetch is made.
- R2: The virtual address splits into a section number in bits 31:20 and an offset in bits 19:0. A translated address is descriptor bits 31:20 followed by virtual bits 19:0.
- R3: The descriptor fetch address is table base bits 31:14, then the 12-bit section number, then 2'b00. mem_req_o and mem_addr_o stay steady until mem_rvalid_i is seen.
- R4: A descriptor is a valid section only when bits 1:0 equal 2'b10. Any other value, including all zeros, answers with rsp_fault_o high, rsp_paddr_o zero and rsp_cacheable_o low. It is not cached, so the next access to that section fetches again.
- R5: On a miss, req_ready_o stays low from the cycle after acceptance until the response. The response comes one cycle after mem_rvalid_i.
- R6: A TLB hit answers one cycle after acceptance without a memory fetch.
- R7: Descriptor bit 17 is the not-global flag. When it is clear, the cached entry matches any ASID. When it is set, the entry matches only the ASID that was current at acceptance of the request that loaded it, and it is still usable after switching away from that ASID and back.
- R8: rsp_cacheable_o is the OR of descriptor bit 14 (top bit of the memory-type field) and bit 3 (the C bit). Device and strongly-ordered encodings, where both are zero, report non-cacheable. A fault is never cacheable.
- R9: The TLB holds TLB_ENTRIES mappings (8 by default) and replaces them in round-robin order. Each fill takes the next slot, valid or not.
- R10: A one-cycle pulse on flush_asid_i removes the not-global entries whose ASID equals flush_asid_val_i. Global entries and entries of other ASIDs are kept.
- R11: A one-cycle pulse on flush_all_i removes every TLB entry.
- R12: After reset, req_ready_o is high, rsp_valid_o and mem_req_o are low, and the TLB is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mmu_en_i | input | 1 | Translation enable, sampled at acceptance |
| tbl_base_i | input | 32 | Table base address (16 KB aligned) |
| asid_i | input | 8 | Current address-space identifier |
| req_valid_i | input | 1 | Request valid |
| req_vaddr_i | input | 32 | Virtual address |
| req_ready_o | output | 1 | Request can be accepted |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_cacheable_o | output | 1 | Mapping is cacheable |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_o | output | 1 | Descriptor fetch in progress |
| mem_addr_o | output | 32 | Descriptor address |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 32 | Descriptor data |
| flush_asid_i | input | 1 | Flush non-global entries of one ASID |
| flush_asid_val_i | input | 8 | ASID to flush |
| flush_all_i | input | 1 | Flush every entry |

## Verification
The bench targets several corner cases:
- The same virtual section is mapped differently under two ASIDs. A TLB that ignored the ASID tag would return the first process's physical section to the second process.
- A global device mapping is reached from another ASID without a fetch, and a non-global one is reached again after a switch back. A design that tagged every entry with an ASID, or that dropped entries on a switch, would show extra fetches.
- Empty and wrongly tagged descriptors are fetched twice in a row. A design that cached faults would skip the second fetch.
- Six fills after the earlier entries wrap the round-robin pointer and evict a global mapping. The flush-by-ASID step must remove only the targeted process's entries, which is seen through the fetch count on later accesses.

// File: rtl/sect_mmu_pkg.sv
package sect_mmu_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 20;
  localparam int unsigned VPN_W   = ADDR_W - OFF_W;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned BASE_LO = VPN_W + 2;  // table alignment bits
  localparam int unsigned NG_BIT  = 17;
  localparam int unsigned TEXH_BIT = 14;
  localparam int unsigned C_BIT   = 3;

  typedef struct packed {
    logic              ng;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic              cach;
  } tlb_ent_t;

  function automatic logic is_section(input logic [1:0] tag);
    return tag == 2'b10;
  endfunction

  function automatic logic is_cacheable(input logic tex_hi, input logic c);
    return tex_hi | c;
  endfunction
endpackage

// File: rtl/sect_mmu_tlb.sv
module sect_mmu_tlb
  import sect_mmu_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [VPN_W-1:0]  lk_ppn_o,
  output logic              lk_cach_o,
  input  logic              fill_i,
  input  tlb_ent_t          fill_ent_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_ent_t           ents [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   rr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic     v_q;
    tlb_ent_t e_q;
    logic     sel;
    assign sel = fill_i && (rr_q == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                               v_q <= 1'b0;
      else if (sel)                                              v_q <= 1'b1;
      else if (flush_all_i)                                      v_q <= 1'b0;
      else if (flush_asid_i && e_q.ng && e_q.asid == flush_asid_val_i) v_q <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (sel) e_q <= fill_ent_i;
    end

    assign vld[g]     = v_q;
    assign ents[g]    = e_q;
    assign hit_vec[g] = v_q && (e_q.vpn == lk_vpn_i) && (!e_q.ng || e_q.asid == lk_asid_i);
  end

  // lowest index wins if a table aliases a global and a private mapping
  always_comb begin
    lk_hit_o  = |hit_vec;
    lk_ppn_o  = '0;
    lk_cach_o = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        lk_ppn_o  = ents[i].ppn;
        lk_cach_o = ents[i].cach;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (fill_i) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  logic unused_vld;
  assign unused_vld = ^vld;
endmodule

// File: rtl/sect_mmu_walk.sv
module sect_mmu_walk
  import sect_mmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] wvaddr_o,
  output logic [ASID_W-1:0] wasid_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i
);
  typedef enum logic {W_IDLE, W_FETCH} wst_e;

  wst_e                       st_q;
  logic [ADDR_W-1:BASE_LO]    base_q;
  logic [ADDR_W-1:0]          va_q;
  logic [ASID_W-1:0]          asid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      base_q <= '0;
      va_q   <= '0;
      asid_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          st_q   <= W_FETCH;
          base_q <= base_i[ADDR_W-1:BASE_LO];
          va_q   <= vaddr_i;
          asid_q <= asid_i;
        end
        W_FETCH: if (mem_rvalid_i) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == W_FETCH);
  assign done_o     = busy_o && mem_rvalid_i;
  assign mem_req_o  = busy_o;
  assign mem_addr_o = {base_q, va_q[ADDR_W-1:OFF_W], 2'b00};
  assign wvaddr_o   = va_q;
  assign wasid_o    = asid_q;

  logic unused_base;
  assign unused_base = ^base_i[BASE_LO-1:0];
endmodule

// File: rtl/sect_mmu.sv
module sect_mmu
  import sect_mmu_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mmu_en_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_cacheable_o,
  output logic              rsp_fault_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i,
  input  logic              flush_all_i
);
  logic              lk_hit, lk_cach, busy, done, accept, start, desc_ok;
  logic [VPN_W-1:0]  lk_ppn;
  logic [ADDR_W-1:0] w_va;
  logic [ASID_W-1:0] w_asid;
  tlb_ent_t          fill_ent;

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && mmu_en_i && !lk_hit;
  assign desc_ok     = is_section(mem_rdata_i[1:0]);

  assign fill_ent.ng   = mem_rdata_i[NG_BIT];
  assign fill_ent.asid = w_asid;
  assign fill_ent.vpn  = w_va[ADDR_W-1:OFF_W];
  assign fill_ent.ppn  = mem_rdata_i[ADDR_W-1:OFF_W];
  assign fill_ent.cach = is_cacheable(mem_rdata_i[TEXH_BIT], mem_rdata_i[C_BIT]);

  sect_mmu_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .lk_vpn_i         (req_vaddr_i[ADDR_W-1:OFF_W]),
    .lk_asid_i        (asid_i),
    .lk_hit_o         (lk_hit),
    .lk_ppn_o         (lk_ppn),
    .lk_cach_o        (lk_cach),
    .fill_i           (done && desc_ok),
    .fill_ent_i       (fill_ent),
    .flush_all_i      (flush_all_i),
    .flush_asid_i     (flush_asid_i),
    .flush_asid_val_i (flush_asid_val_i)
  );

  sect_mmu_walk u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .vaddr_i      (req_vaddr_i),
    .asid_i       (asid_i),
    .base_i       (tbl_base_i),
    .busy_o       (busy),
    .done_o       (done),
    .wvaddr_o     (w_va),
    .wasid_o      (w_asid),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_paddr_o     <= '0;
      rsp_cacheable_o <= 1'b0;
      rsp_fault_o     <= 1'b0;
    end else if (accept && (!mmu_en_i || lk_hit)) begin
      rsp_valid_o     <= 1'b1;
      rsp_paddr_o     <= mmu_en_i ? {lk_ppn, req_vaddr_i[OFF_W-1:0]} : req_vaddr_i;
      rsp_cacheable_o <= mmu_en_i && lk_cach;
      rsp_fault_o     <= 1'b0;
    end else if (done) begin
      rsp_valid_o     <= 1'b1;
      rsp_paddr_o     <= desc_ok ? {mem_rdata_i[ADDR_W-1:OFF_W], w_va[OFF_W-1:0]} : '0;
      rsp_cacheable_o <= desc_ok && fill_ent.cach;
      rsp_fault_o     <= !desc_ok;
    end else begin
      rsp_valid_o     <= 1'b0;
    end
  end
endmodule

module sect_mmu_chk
  import sect_mmu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mmu_en_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic              rsp_cacheable_o,
  input logic              rsp_fault_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [ADDR_W-1:0] mem_rdata_i
);
  AST_BYPASS_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !mmu_en_i |=> rsp_valid_o && rsp_paddr_o == $past(req_vaddr_i)
      && !rsp_fault_o && !rsp_cacheable_o); // R1
  AST_BYPASS_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !mmu_en_i |=> !mem_req_o); // R1
  AST_SECTION_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && mem_rdata_i[1:0] == 2'b10 |=> rsp_valid_o && !rsp_fault_o
      && rsp_paddr_o[ADDR_W-1:OFF_W] == $past(mem_rdata_i[ADDR_W-1:OFF_W])); // R2
  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_FETCH_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R3
  AST_BAD_DESC_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && mem_rdata_i[1:0] != 2'b10 |=> rsp_valid_o && rsp_fault_o
      && rsp_paddr_o == '0); // R4
  AST_STALL_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R5
  AST_CACHE_ATTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && mem_rdata_i[1:0] == 2'b10 |=>
      rsp_cacheable_o == $past(mem_rdata_i[TEXH_BIT] | mem_rdata_i[C_BIT])); // R8
  AST_FAULT_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> !rsp_cacheable_o); // R8
endmodule

bind sect_mmu sect_mmu_chk u_chk (.*);

// File: tb/sect_mmu_tb.sv
module sect_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmu_en = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [7:0]  asid = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_c, rsp_f, mem_req;
  logic [31:0] rsp_pa, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fl_asid = 1'b0, fl_all = 1'b0;
  logic [7:0]  fl_asid_val = '0;

  int checks = 0, errors = 0, walks = 0, exp_walks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] pa;
    logic        c;
    logic        f;
    int          nwalk;
    logic [31:0] maddr;
    string       tag;
  } exp_t;
  exp_t sbq[$];
  logic [31:0] tbl [logic [31:0]];

  localparam logic [31:0] B1 = 32'h0003_4000;
  localparam logic [31:0] B2 = 32'h0003_8000;

  always #2 clk = ~clk;

  sect_mmu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mmu_en_i(mmu_en), .tbl_base_i(tbl_base), .asid_i(asid),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_pa), .rsp_cacheable_o(rsp_c), .rsp_fault_o(rsp_f),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .flush_asid_i(fl_asid), .flush_asid_val_i(fl_asid_val), .flush_all_i(fl_all)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic issue(input logic [31:0] va, input logic [31:0] pa, input logic c,
                       input logic f, input bit walk, input string tag);
    exp_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    if (walk && mmu_en) exp_walks++;
    it.pa = pa; it.c = c; it.f = f; it.nwalk = exp_walks; it.tag = tag;
    it.maddr = {tbl_base[31:14], va[31:20], 2'b00};
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic pulse_flush(input bit all, input logic [7:0] a);
    drain();
    @(negedge clk);
    fl_all = all; fl_asid = !all; fl_asid_val = a;
    @(negedge clk);
    fl_all = 1'b0; fl_asid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R5 unexpected response", rsp_pa, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rsp_pa == e.pa && rsp_c == e.c && rsp_f == e.f,
            {e.tag, " pa/c/f"}, {rsp_pa[31:2], rsp_c, rsp_f}, {e.pa[31:2], e.c, e.f});
        chk(walks == e.nwalk, {e.tag, " fetch count"}, 32'(walks), 32'(e.nwalk));
      end
    end
  end

  // descriptor memory, two-cycle latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rst_n && mem_req) begin
        if (sbq.size() == 0) chk(1'b0, "R3 fetch without request", mem_addr, 32'h0);
        else chk(mem_addr == sbq[$].maddr, "R3 fetch address", mem_addr, sbq[$].maddr);
        repeat (2) @(negedge clk);
        mem_rdata  = tbl.exists(mem_addr) ? tbl[mem_addr] : 32'h0;
        mem_rvalid = 1'b1;
        walks++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // table contents: asid1 at B1, asid2 at B2
    tbl[B1 + 32'h4]        = 32'h0022_6C0A;              // vpn 1 -> ppn 2, ng, cacheable
    tbl[B1 + 32'hC]        = 32'h0050_0C01;              // vpn 3, wrong type tag
    tbl[B1 + 32'h3F0*4]    = 32'h3F00_0006;              // device, global
    tbl[B2 + 32'h4]        = 32'h0042_6C0A;              // vpn 1 -> ppn 4, ng
    for (int k = 0; k < 6; k++)
      tbl[B1 + 32'((32'h100 + k) * 4)] = (32'(32'h200 + k) << 20) | 32'h0002_0002 |
        ((k == 2) ? 32'h1000 : ((k % 2) == 1 ? 32'h4000 : 32'h8));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R12 no response after reset", 32'(rsp_valid), 32'h0);
    chk(mem_req == 1'b0, "R12 no fetch after reset", 32'(mem_req), 32'h0);

    issue(32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0, "R1 bypass");

    mmu_en = 1'b1; asid = 8'd1; tbl_base = B1;
    issue(32'h0010_0ABC, 32'h0020_0ABC, 1'b1, 1'b0, 1'b1, "R2 R3 R5 R8 miss fill");
    issue(32'h0010_0ABC, 32'h0020_0ABC, 1'b1, 1'b0, 1'b0, "R6 hit");
    issue(32'h001F_FFFF, 32'h002F_FFFF, 1'b1, 1'b0, 1'b0, "R2 R6 hit page top");
    issue(32'h0020_0010, 32'h0, 1'b0, 1'b1, 1'b1, "R4 empty descriptor");
    issue(32'h0020_0010, 32'h0, 1'b0, 1'b1, 1'b1, "R4 fault not cached");
    issue(32'h0030_0000, 32'h0, 1'b0, 1'b1, 1'b1, "R4 wrong tag");
    issue(32'h3F01_2345, 32'h3F01_2345, 1'b0, 1'b0, 1'b1, "R8 device uncached");

    drain();
    asid = 8'd2; tbl_base = B2;
    issue(32'h0010_0000, 32'h0040_0000, 1'b1, 1'b0, 1'b1, "R7 other asid misses");
    issue(32'h3F01_0000, 32'h3F01_0000, 1'b0, 1'b0, 1'b0, "R7 global shared");
    drain();
    asid = 8'd1; tbl_base = B1;
    issue(32'h0010_0004, 32'h0020_0004, 1'b1, 1'b0, 1'b0, "R7 entry kept over switch");

    pulse_flush(1'b0, 8'd1);
    issue(32'h0010_0008, 32'h0020_0008, 1'b1, 1'b0, 1'b1, "R10 flushed asid refetch");
    issue(32'h3F00_0000, 32'h3F00_0000, 1'b0, 1'b0, 1'b0, "R10 global kept");
    drain();
    asid = 8'd2; tbl_base = B2;
    issue(32'h0010_0000, 32'h0040_0000, 1'b1, 1'b0, 1'b0, "R10 other asid kept");
    drain();
    asid = 8'd1; tbl_base = B1;

    for (int k = 0; k < 6; k++)
      issue({12'(12'h100 + k), 20'h00ABC}, {12'(12'h200 + k), 20'h00ABC},
            (k != 2), 1'b0, 1'b1, "R8 R9 fill");
    issue(32'h1000_0000, 32'h2000_0000, 1'b1, 1'b0, 1'b0, "R9 recent entry kept");
    issue(32'h3F00_0040, 32'h3F00_0040, 1'b0, 1'b0, 1'b1, "R9 round robin evicted");

    pulse_flush(1'b1, 8'd0);
    issue(32'h0010_0000, 32'h0020_0000, 1'b1, 1'b0, 1'b1, "R11 flush all refetch");
    issue(32'h1010_0000, 32'h2010_0000, 1'b1, 1'b0, 1'b1, "R11 flush all refetch 2");

    drain();
    mmu_en = 1'b0;
    issue(32'h0010_0000, 32'h0010_0000, 1'b0, 1'b0, 1'b0, "R1 bypass after use");
    drain();
    repeat (4) @(negedge clk);
    chk(walks == exp_walks, "R1 total fetches", 32'(walks), 32'(exp_walks));
    done = 1;
    summary();
    $finish;
  end
endmodule